// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Idle Line Release

This block is the master side of a synchronous serial link that uses the frame-pulse word format. It makes the serial clock from the system clock. It drives a frame strobe one serial clock wide just before each word. It shifts parallel words of 4 to 32 bits out on the data line, most significant bit first. While it sends, it captures bits from a receive input and returns each finished word as a parallel value.

Words arrive through a valid/ready handshake. When the next word is waiting by the time the last bit of the current word starts, the two words run with no idle clocks between them.

The transmit line can be released to high impedance when no word is being sent. The block gives the data value and a registered output enable as separate outputs, so the three-state buffer sits at the chip level. A late-release control sets when the line is released after the final bit: half a serial clock after that bit starts, or a full serial clock after it starts.

Top module: `ssp_tri_tx`

## Requirements
- R1: The word length is `cfg_bits`. Values below 4 are used as 4, and values above 32 are used as 32. Bits go out most significant first. Bit k of the word is on `txd` in the serial clock period that starts at the (length-k)-th rising edge after the frame edge. Bits of `tx_data` above the word length are ignored.
- R2: `sfrm` rises together with a rising edge of `sclk` and stays high for exactly one serial clock period. The word's MSB appears at the rising edge where `sfrm` falls.
- R3: With `cfg_tri` = 0, `txd_oe` stays 1. Between words `txd` keeps the value of the last bit sent.
- R4: With `cfg_tri` = 1, `txd_oe` rises at the rising `sclk` edge that puts the MSB on the line, and not earlier. `txd` changes only at rising `sclk` edges while it is driven.
- R5: With `cfg_tri` = 1 and `cfg_late` = 0, when no word follows, `txd_oe` falls at the falling `sclk` edge inside the LSB period.
- R6: With `cfg_tri` = 1 and `cfg_late` = 1, when no word follows, `txd_oe` falls at the rising `sclk` edge that ends the LSB period.
- R7: If `tx_valid` is high at the rising edge that starts an LSB, the next word is taken there. `sfrm` pulses during that LSB, the new MSB follows at the next rising edge, and `txd_oe` stays 1 across the boundary.
- R8: `rxd` is sampled at each falling `sclk` edge inside a bit period. At the falling edge inside the LSB period, `rx_valid` is high for one system clock and `rx_data` holds the word right aligned, with zeros above it.
- R9: `sclk` toggles every D system clocks, where D = `cfg_div`. Values below 2 are used as 2. `sclk` starts low after reset or after enable.
- R10: While `rst` is high or `en` is low: `sclk`, `sfrm`, `txd`, `rx_valid` and `tx_ready` are 0, and `txd_oe` equals the inverse of `cfg_tri`.
- R11: `tx_ready` is high only in the system clock just before a rising `sclk` edge, and only when a word can start at that edge (idle, or the edge that starts an LSB). A word is taken when `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block enable; low holds the idle state |
| cfg_bits | input | 6 | Word length in bits (4 to 32) |
| cfg_div | input | 8 | System clocks per half serial clock (minimum 2) |
| cfg_tri | input | 1 | Release the data line while idle |
| cfg_late | input | 1 | Release one full serial clock after the LSB starts, not half |
| tx_data | input | 32 | Word to send, right aligned |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block takes the word at this clock |
| rx_data | output | 32 | Received word, right aligned |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| rxd | input | 1 | Serial receive data |
| sclk | output | 1 | Serial clock |
| sfrm | output | 1 | Frame strobe |
| txd | output | 1 | Serial transmit data value |
| txd_oe | output | 1 | Output enable for the transmit data buffer |

## Verification
Two pairs of events can land on the same system clock edge. In early-release mode, the falling edge inside the LSB both drops `txd_oe` and completes the received word. At the LSB's rising edge, the last bit goes out on the same edge that takes the next word and raises `sfrm`. The bench sets up both cases with single gapped words under early release, and with queued words of 4, 16 and 32 bits. A behavioural model compares every output on every clock. In the back-to-back case it also checks that `txd_oe` never drops across the word boundary.

// File: rtl/ssp_tx_pkg.sv
package ssp_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_BITS,
        ST_TAIL
    } tx_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    function automatic int clamp_bits(input int req, input int maxw);
        if (req < 4)
            return 4;
        if (req > maxw)
            return maxw;
        return req;
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_tx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             sclk,
    output sclk_evt_t        evt
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;
    logic             sclk_q;
    logic             wrap;

    always_comb begin
        div_eff  = (cfg_div < MIN_DIV) ? MIN_DIV : cfg_div;
        wrap     = (cnt_q >= div_eff - 1'b1);
        evt.rise = en && wrap && !sclk_q;
        evt.fall = en && wrap && sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sclk = sclk_q;

    // R9
    edge_spacing_chk: assert property (@(posedge clk) disable iff (rst || !en)
        evt.rise |=> !evt.rise && !evt.fall);

endmodule

// File: rtl/ssp_shift_ctrl.sv
module ssp_shift_ctrl
    import ssp_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BITS_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  sclk_evt_t         evt,
    input  logic [BITS_W-1:0] bits_eff,
    input  logic              cfg_tri,
    input  logic              cfg_late,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              sfrm,
    output logic              txd,
    output logic              txd_oe,
    output logic              bit_active,
    output logic              bit_last
);
    localparam int IDX_W = $clog2(WORD_W);

    tx_state_e         state_q;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_nxt;
    logic [IDX_W-1:0]  msb_sel;
    logic [BITS_W-1:0] bits_m1;
    logic              lsb_q;
    logic              sfrm_q;
    logic              txd_q;
    logic              oe_q;
    logic              take;

    always_comb begin
        bits_m1  = bits_eff - 1'b1;
        msb_sel  = bits_m1[IDX_W-1:0];
        idx_nxt  = idx_q - 1'b1;
        tx_ready = evt.rise && ((state_q == ST_IDLE) || (state_q == ST_TAIL) ||
                   ((state_q == ST_BITS) && (idx_q == IDX_W'(1))));
        take     = tx_ready && tx_valid;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            idx_q   <= '0;
            lsb_q   <= 1'b0;
            sfrm_q  <= 1'b0;
            txd_q   <= 1'b0;
            oe_q    <= !cfg_tri;
        end else begin
            if (evt.fall && (state_q == ST_TAIL) && cfg_tri && !cfg_late)
                oe_q <= 1'b0;
            if (evt.rise) begin
                unique case (state_q)
                    ST_IDLE, ST_TAIL: begin
                        oe_q  <= !cfg_tri;
                        lsb_q <= 1'b0;
                        if (take) begin
                            word_q  <= tx_data;
                            sfrm_q  <= 1'b1;
                            state_q <= ST_FRAME;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_FRAME: begin
                        sfrm_q  <= 1'b0;
                        txd_q   <= word_q[msb_sel];
                        oe_q    <= 1'b1;
                        idx_q   <= msb_sel;
                        lsb_q   <= 1'b0;
                        state_q <= ST_BITS;
                    end
                    ST_BITS: begin
                        idx_q <= idx_nxt;
                        txd_q <= word_q[idx_nxt];
                        if (idx_nxt == '0) begin
                            lsb_q <= 1'b1;
                            if (take) begin
                                word_q  <= tx_data;
                                sfrm_q  <= 1'b1;
                                state_q <= ST_FRAME;
                            end else begin
                                state_q <= ST_TAIL;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sfrm       = sfrm_q;
    assign txd        = txd_q;
    assign txd_oe     = oe_q;
    assign bit_active = (state_q == ST_BITS) || lsb_q;
    assign bit_last   = lsb_q;

    // R7
    b2b_drive_chk: assert property (@(posedge clk) disable iff (rst || !en)
        (lsb_q && state_q == ST_FRAME) |-> oe_q);

    // R11
    ready_single_chk: assert property (@(posedge clk) disable iff (rst || !en)
        tx_ready |=> !tx_ready);

endmodule

// File: rtl/ssp_rx_deser.sv
module ssp_rx_deser
    import ssp_tx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  sclk_evt_t         evt,
    input  logic              rxd,
    input  logic              bit_active,
    input  logic              bit_last,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] sh_nxt;
    logic [WORD_W-1:0] data_q;
    logic              valid_q;

    always_comb sh_nxt = (sh_q << 1) | WORD_W'(rxd);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sh_q    <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (evt.fall && bit_active) begin
                if (bit_last) begin
                    data_q  <= sh_nxt;
                    valid_q <= 1'b1;
                    sh_q    <= '0;
                end else begin
                    sh_q    <= sh_nxt;
                end
            end
        end
    end

    assign rx_data  = data_q;
    assign rx_valid = valid_q;

    // R8
    rx_strobe_chk: assert property (@(posedge clk) disable iff (rst || !en)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/ssp_tri_tx.sv
module ssp_tri_tx
    import ssp_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 8,
    localparam int BITS_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_tri,
    input  logic              cfg_late,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rxd,
    output logic              sclk,
    output logic              sfrm,
    output logic              txd,
    output logic              txd_oe
);
    sclk_evt_t         evt;
    logic [BITS_W-1:0] bits_eff;
    logic              bit_active;
    logic              bit_last;

    assign bits_eff = BITS_W'(clamp_bits(int'(cfg_bits), WORD_W));

    ssp_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .en(en), .cfg_div(cfg_div),
        .sclk(sclk), .evt(evt)
    );

    ssp_shift_ctrl #(.WORD_W(WORD_W), .BITS_W(BITS_W)) u_ctrl (
        .clk(clk), .rst(rst), .en(en), .evt(evt), .bits_eff(bits_eff),
        .cfg_tri(cfg_tri), .cfg_late(cfg_late), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .sfrm(sfrm), .txd(txd),
        .txd_oe(txd_oe), .bit_active(bit_active), .bit_last(bit_last)
    );

    ssp_rx_deser #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst(rst), .en(en), .evt(evt), .rxd(rxd),
        .bit_active(bit_active), .bit_last(bit_last),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    // R2
    frame_edge_chk: assert property (@(posedge clk) disable iff (rst || !en)
        $rose(sfrm) |-> $rose(sclk));

    // R4
    txd_hold_chk: assert property (@(posedge clk) disable iff (rst || !en)
        ($past(en) && txd_oe && !$rose(sclk)) |-> $stable(txd));

endmodule

// File: tb/ssp_tri_tx_test.sv
`timescale 1ns/1ps
module ssp_tri_tx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [5:0]  cfg_bits = 6'd8;
    logic [7:0]  cfg_div = 8'd2;
    logic        cfg_tri = 1'b0;
    logic        cfg_late = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic        rxd = 1'b0;
    logic        sclk, sfrm, txd, txd_oe;

    always #4 clk = ~clk;

    ssp_tri_tx uut (
        .clk(clk), .rst(rst), .en(en), .cfg_bits(cfg_bits), .cfg_div(cfg_div),
        .cfg_tri(cfg_tri), .cfg_late(cfg_late), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .rxd(rxd), .sclk(sclk), .sfrm(sfrm),
        .txd(txd), .txd_oe(txd_oe)
    );

    int checks = 0;
    int failures = 0;
    logic [31:0] q[$];
    logic [15:0] lfsr = 16'hACE1;
    bit started = 0;

    // reference model state: 0 idle, 1 frame, 2 bits, 3 tail
    int          m_cnt, m_mode, m_idx;
    bit          m_sclk, m_sfrm, m_txd, m_oe, m_lsb, m_rxv;
    logic [31:0] m_word;
    longint      m_acc;
    logic [31:0] m_rxword;

    function automatic int eff_div();
        return (cfg_div < 2) ? 2 : int'(cfg_div);
    endfunction

    function automatic int eff_bits();
        if (cfg_bits < 4) return 4;
        if (cfg_bits > 32) return 32;
        return int'(cfg_bits);
    endfunction

    function automatic bit model_rise();
        return en && !rst && (m_cnt >= eff_div() - 1) && !m_sclk;
    endfunction

    function automatic bit model_ready();
        return model_rise() && (m_mode == 0 || m_mode == 3 || (m_mode == 2 && m_idx == 1));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit r, f, wrap, take;
        started = 1;
        if (rst || !en) begin
            m_cnt = 0; m_sclk = 0; m_sfrm = 0; m_txd = 0; m_oe = !cfg_tri;
            m_mode = 0; m_idx = 0; m_lsb = 0; m_rxv = 0; m_acc = 0; m_word = '0;
            m_rxword = '0;
        end else begin
            wrap = (m_cnt >= eff_div() - 1);
            r = wrap && !m_sclk;
            f = wrap && m_sclk;
            take = model_ready() && tx_valid;
            m_rxv = 0;
            if (f) begin
                if (m_mode == 2 || m_lsb) begin
                    m_acc = (m_acc << 1) | longint'(rxd);
                    if (m_lsb) begin
                        m_rxword = m_acc[31:0];
                        m_rxv = 1;
                        m_acc = 0;
                    end
                end
                if (m_mode == 3 && cfg_tri && !cfg_late) m_oe = 0;
            end
            if (r) begin
                if (m_mode == 0 || m_mode == 3) begin
                    m_oe = !cfg_tri;
                    m_lsb = 0;
                    if (take) begin
                        m_word = q.pop_front();
                        m_sfrm = 1;
                        m_mode = 1;
                    end else m_mode = 0;
                end else if (m_mode == 1) begin
                    m_sfrm = 0;
                    m_idx = eff_bits() - 1;
                    m_txd = m_word[m_idx];
                    m_oe = 1;
                    m_lsb = 0;
                    m_mode = 2;
                end else begin
                    m_idx = m_idx - 1;
                    m_txd = m_word[m_idx];
                    if (m_idx == 0) begin
                        m_lsb = 1;
                        if (take) begin
                            m_word = q.pop_front();
                            m_sfrm = 1;
                            m_mode = 1;
                        end else m_mode = 3;
                    end
                end
            end
            if (wrap) begin
                m_cnt = 0;
                m_sclk = !m_sclk;
            end else m_cnt = m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        string oe_req;
        bit idle_st;
        if (started) begin
            idle_st = rst || !en;
            chk(sclk === m_sclk, idle_st ? "R10" : "R9", 32'(sclk), 32'(m_sclk));
            chk(sfrm === m_sfrm, idle_st ? "R10" : "R2", 32'(sfrm), 32'(m_sfrm));
            if (idle_st) oe_req = "R10";
            else if (m_mode == 1 && m_lsb) oe_req = "R7";
            else if (!cfg_tri) oe_req = "R3";
            else if (m_mode == 3 && cfg_late) oe_req = "R6";
            else if (m_mode == 3) oe_req = "R5";
            else oe_req = "R4";
            chk(txd_oe === m_oe, oe_req, 32'(txd_oe), 32'(m_oe));
            if (m_oe) chk(txd === m_txd, idle_st ? "R10" : "R1", 32'(txd), 32'(m_txd));
            chk(tx_ready === model_ready(), idle_st ? "R10" : "R11", 32'(tx_ready), 32'(model_ready()));
            chk(rx_valid === m_rxv, idle_st ? "R10" : "R8", 32'(rx_valid), 32'(m_rxv));
            if (m_rxv) chk(rx_data === m_rxword, "R8", rx_data, m_rxword);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rxd = lfsr[0];
        tx_valid = (q.size() != 0);
        tx_data = (q.size() != 0) ? q[0] : 32'h0;
    end

    task automatic setup(input int bits, input int div, input bit tri_en, input bit late);
        @(negedge clk);
        rst = 1'b1;
        cfg_bits = 6'(bits); cfg_div = 8'(div); cfg_tri = tri_en; cfg_late = late;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        en = 1'b1;
    endtask

    task automatic drain();
        while (q.size() != 0 || m_mode != 0) @(negedge clk);
        repeat (4 * eff_div() + 4) @(negedge clk);
    endtask

    task automatic send(input int n, input bit b2b, input int seed);
        for (int i = 0; i < n; i++) begin
            q.push_back(32'h9E3779B9 * (seed + i + 1) ^ 32'h5A5AC3C3);
            if (!b2b) begin
                drain();
                repeat (5) @(negedge clk);
            end
        end
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 R3 R1: driven line, queued words
        setup(8, 2, 0, 0);  send(3, 1, 1);
        // R5 R4 R8: early release, gapped words
        setup(8, 2, 1, 0);  send(3, 0, 7);
        // R6: late release, odd divider
        setup(8, 3, 1, 1);  send(3, 0, 13);
        // R7 with early release selected
        setup(16, 2, 1, 0); send(4, 1, 21);
        // R7 R6 shortest word
        setup(4, 2, 1, 1);  send(5, 1, 31);
        // R1 widest word, gapped
        setup(32, 3, 1, 0); send(2, 0, 41);
        // R1 R9 clamps: length 2 -> 4, divider 1 -> 2
        setup(2, 1, 1, 0);  send(3, 1, 51);
        // R1 clamp: length 45 -> 32, driven line
        setup(45, 2, 0, 0); send(2, 1, 61);
        // R10: drop enable in mid word, then resume
        setup(12, 2, 1, 1);
        q.push_back(32'hABC); q.push_back(32'h5A5);
        repeat (40) @(negedge clk);
        en = 1'b0;
        repeat (12) @(negedge clk);
        en = 1'b1;
        drain();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule